// File: doc/BRIEF.md
# Programmable Periodic Interrupt Divider

This block turns a 32768 Hz clock-enable tick into a programmable periodic event. A 4-bit rate code selects a period that is a power of two in ticks. Each event can produce two outputs. One is a one-cycle periodic strobe, which the surrounding logic uses to set its periodic and interrupt-request flags and to raise the interrupt. The other is a one-cycle pulse on the square-wave output, which replaces a continuous square wave.

The divider does not count from the moment the rate is written. It watches a free-running 15-bit count of ticks that starts at reset, and an event fires when that count lands on a multiple of the selected period. A change of rate therefore takes effect at once: the next event falls on the next multiple of the new period. The divider runs only when the rate code is nonzero and at least one of the two enables is set. Each enable gates only its own output.

Top module: `pid_divider`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `prd_strobe` and `sqw_pulse` are 0. The tick count is cleared to 0 by reset.
- R2: When `rate_code` is 0, neither output ever pulses, whatever the enables are.
- R3: For a `rate_code` c in 3..15, the event period is 2^(c-1) ticks.
- R4: A `rate_code` of 1 gives a period of 128 ticks, and a code of 2 gives 256 ticks. These are the periods of codes 8 and 9.
- R5: The tick count increments by 1 on every cycle with `tick_32k` high and wraps at 2^15. An event fires on the tick that makes the count a multiple of the period. A rate change therefore moves the next event to the next multiple of the new period.
- R6: `prd_strobe` is high for exactly one cycle, in the cycle after the tick that causes an event, and only if `prd_en` was high at that tick.
- R7: `sqw_pulse` is high for exactly one cycle, in the cycle after the tick that causes an event, and only if `sqw_en` was high at that tick. It is never held high as a level.
- R8: Cycles with `tick_32k` low neither advance the count nor cause an event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_32k | input | 1 | One-cycle enable at 32768 Hz |
| rate_code | input | 4 | Rate select; 0 turns the divider off |
| prd_en | input | 1 | Periodic event enable |
| sqw_en | input | 1 | Square-wave pulse enable |
| prd_strobe | output | 1 | One-cycle periodic event strobe |
| sqw_pulse | output | 1 | One-cycle square-wave pulse |

## Verification
All of this block's state is the tick count. If that count is wrong, the events shift away from multiples of the period. The error shows up at the very next event, at most 2^14 ticks later, and it shows up as early as 4 ticks later when the shortest period is selected. The bench keeps its own tick count from reset and compares both outputs with it every cycle. It also counts the events in windows that are whole multiples of each period. A fault in the rate remapping or in the period mask then shows as a wrong event total, and a missed or doubled strobe shows at once as a mismatch in that cycle.

// File: rtl/pid_pkg.sv
// Package for the periodic interrupt divider.
// Holds the default widths and the rate-code remapping shared by all modules.
package pid_pkg;
    localparam int PID_RATE_W  = 4;
    localparam int PID_CNT_W   = 15;
    // Codes up to this value are moved upward by PID_LOW_SHIFT.
    localparam int PID_LOW_MAX   = 2;
    localparam int PID_LOW_SHIFT = 7;

    // Decoded form of a rate code.
    typedef struct packed {
        logic       active;   // nonzero code
        logic [4:0] log2_per; // log2 of period in ticks
    } pid_rate_t;
endpackage

// File: rtl/pid_tick_counter.sv
// Free-running tick counter.
// Counts every cycle that has the tick enable high and wraps at 2^CNT_W.
// Assumes the tick is a one-cycle enable in the clk domain.
module pid_tick_counter #(
    parameter int CNT_W = pid_pkg::PID_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_inc
);
    // Value the count takes on the next tick.
    always_comb cnt_inc = cnt_q + 1'b1;

    // Advance the count on each tick; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_inc;
    end
endmodule

// File: rtl/pid_rate_decode.sv
// Rate decoder.
// Maps a rate code to an activity flag and to a mask of the count bits that
// must all be zero at an event. Codes 1..LOW_MAX are remapped upward by
// LOW_SHIFT. Assumes the longest period fits inside the counter width.
module pid_rate_decode #(
    parameter int RATE_W    = pid_pkg::PID_RATE_W,
    parameter int CNT_W     = pid_pkg::PID_CNT_W,
    parameter int LOW_MAX   = pid_pkg::PID_LOW_MAX,
    parameter int LOW_SHIFT = pid_pkg::PID_LOW_SHIFT
) (
    input  logic [RATE_W-1:0] code,
    output pid_pkg::pid_rate_t rate,
    output logic [CNT_W-1:0]  mask
);
    localparam int EFF_W = RATE_W + 1;

    logic [EFF_W-1:0] eff_code;

    // Remap low codes and derive log2 of the period.
    always_comb begin
        if (32'(code) <= LOW_MAX)
            eff_code = EFF_W'(code) + EFF_W'(LOW_SHIFT);
        else
            eff_code = EFF_W'(code);
        rate.active   = (code != '0);
        rate.log2_per = 5'(eff_code - 1'b1);
    end

    // One mask bit per counter bit below log2 of the period.
    for (genvar g = 0; g < CNT_W; g++) begin : g_mask
        assign mask[g] = (32'(g) < 32'(rate.log2_per));
    end
endmodule

// File: rtl/pid_event_gen.sv
// Event generator.
// Fires on the tick whose new count value has all masked bits at zero, and
// registers one-cycle outputs gated by their own enables.
// Assumes the period is at least two ticks, so outputs never last two cycles.
module pid_event_gen #(
    parameter int CNT_W = pid_pkg::PID_CNT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  pid_pkg::pid_rate_t rate,
    input  logic [CNT_W-1:0]   mask,
    input  logic [CNT_W-1:0]   cnt_inc,
    input  logic               prd_en,
    input  logic               sqw_en,
    output logic               prd_strobe,
    output logic               sqw_pulse
);
    logic running;
    logic hit;

    // Divider runs with a nonzero code and at least one enable; hit on aligned ticks.
    always_comb begin
        running = rate.active && (prd_en || sqw_en);
        hit     = tick && running && ((cnt_inc & mask) == '0);
    end

    // Register the gated one-cycle outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prd_strobe <= 1'b0;
            sqw_pulse  <= 1'b0;
        end else begin
            prd_strobe <= hit && prd_en;
            sqw_pulse  <= hit && sqw_en;
        end
    end
endmodule

// File: rtl/pid_divider.sv
// Programmable periodic interrupt divider, top level.
// Divides the 32768 Hz tick by a power of two picked by the rate code, with
// events aligned to a free-running count, and drives a periodic strobe and a
// square-wave pulse. Assumes a synchronous active-low reset.
module pid_divider #(
    parameter int RATE_W = pid_pkg::PID_RATE_W,
    parameter int CNT_W  = pid_pkg::PID_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_32k,
    input  logic [RATE_W-1:0] rate_code,
    input  logic              prd_en,
    input  logic              sqw_en,
    output logic              prd_strobe,
    output logic              sqw_pulse
);
    logic [CNT_W-1:0]   count_q;
    logic [CNT_W-1:0]   count_inc;
    logic [CNT_W-1:0]   per_mask;
    pid_pkg::pid_rate_t rate_dec;

    pid_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_32k),
        .cnt_q   (count_q),
        .cnt_inc (count_inc)
    );

    pid_rate_decode #(.RATE_W(RATE_W), .CNT_W(CNT_W)) u_dec (
        .code (rate_code),
        .rate (rate_dec),
        .mask (per_mask)
    );

    pid_event_gen #(.CNT_W(CNT_W)) u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_32k),
        .rate       (rate_dec),
        .mask       (per_mask),
        .cnt_inc    (count_inc),
        .prd_en     (prd_en),
        .sqw_en     (sqw_en),
        .prd_strobe (prd_strobe),
        .sqw_pulse  (sqw_pulse)
    );
endmodule

// File: rtl/pid_divider_chk.sv
// Assertion checker for pid_divider, attached with bind.
// Relates the outputs to the inputs of the previous cycle and to the tick count.
module pid_divider_chk #(
    parameter int RATE_W = pid_pkg::PID_RATE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_32k,
    input logic [RATE_W-1:0] rate_code,
    input logic              prd_en,
    input logic              sqw_en,
    input logic              prd_strobe,
    input logic              sqw_pulse,
    input logic [1:0]        cnt_low
);
    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        prd_strobe |=> !prd_strobe); // R6
    AST_STROBE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        prd_strobe |-> $past(prd_en)); // R6
    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sqw_pulse |=> !sqw_pulse); // R7
    AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        sqw_pulse |-> $past(sqw_en)); // R7
    AST_OFF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (prd_strobe || sqw_pulse) |-> ($past(rate_code) != '0)); // R2
    AST_EVENT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (prd_strobe || sqw_pulse) |-> $past(tick_32k)); // R8
    AST_EVENT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (prd_strobe || sqw_pulse) |-> (cnt_low == 2'b00)); // R5
endmodule

bind pid_divider pid_divider_chk #(.RATE_W(RATE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_32k   (tick_32k),
    .rate_code  (rate_code),
    .prd_en     (prd_en),
    .sqw_en     (sqw_en),
    .prd_strobe (prd_strobe),
    .sqw_pulse  (sqw_pulse),
    .cnt_low    (count_q[1:0])
);

// File: tb/pid_divider_test.sv
module pid_divider_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_32k = 1'b0;
    logic [3:0] rate_code = 4'd0;
    logic       prd_en = 1'b0;
    logic       sqw_en = 1'b0;
    logic       prd_strobe;
    logic       sqw_pulse;

    int checks = 0;
    int fails = 0;
    int mcnt = 0;
    int n_prd = 0;
    int n_sqw = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pid_divider uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_32k   (tick_32k),
        .rate_code  (rate_code),
        .prd_en     (prd_en),
        .sqw_en     (sqw_en),
        .prd_strobe (prd_strobe),
        .sqw_pulse  (sqw_pulse)
    );

    // Period in ticks, from the requirements; 0 means off.
    function automatic int period_of(input int code);
        int e;
        if (code == 0) return 0;
        e = (code <= 2) ? code + 7 : code;
        return 1 << (e - 1);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one cycle at a negedge, then compare both outputs at the next negedge.
    task automatic step(input bit tk, input int code, input bit pe, input bit se,
                        input string tag);
        int p;
        bit ev;
        tick_32k = tk; rate_code = 4'(code); prd_en = pe; sqw_en = se;
        p = period_of(code);
        ev = tk && (p != 0) && (((mcnt + 1) % p) == 0);
        if (tk) mcnt = (mcnt + 1) % 32768;
        @(negedge clk);
        check(tag, int'(prd_strobe), int'(ev && pe));
        check(tag, int'(sqw_pulse), int'(ev && se));
        if (prd_strobe) n_prd++;
        if (sqw_pulse) n_sqw++;
    endtask

    // Run a window of ticks at one setting and check the event totals.
    task automatic window(input int code, input bit pe, input bit se, input int ticks,
                          input int exp_evts, input string tag);
        n_prd = 0; n_sqw = 0;
        for (int i = 0; i < ticks; i++) step(1'b1, code, pe, se, tag);
        check(tag, n_prd, pe ? exp_evts : 0);
        check(tag, n_sqw, se ? exp_evts : 0);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG_CYCLES);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int seed = 32'h5eed_0042;
        void'($urandom(seed));
        // R1: reset holds outputs low even with ticks and enables.
        tick_32k = 1'b1; rate_code = 4'd3; prd_en = 1'b1; sqw_en = 1'b1;
        repeat (6) begin
            @(negedge clk);
            check("R1", int'(prd_strobe), 0);
            check("R1", int'(sqw_pulse), 0);
        end
        rst_n = 1'b1;
        mcnt = 0;
        // R1, R5: counter starts at 0, so code 3 fires after exactly 4 ticks.
        step(1'b1, 3, 1'b1, 1'b1, "R1");
        step(1'b1, 3, 1'b1, 1'b1, "R1");
        step(1'b1, 3, 1'b1, 1'b1, "R1");
        step(1'b1, 3, 1'b1, 1'b1, "R5");
        check("R5", int'(prd_strobe), 1);

        // R2: code 0 never fires.
        window(0, 1'b1, 1'b1, 600, 0, "R2");
        // R3: code 3 gives period 4; code 15 gives period 16384.
        window(3, 1'b1, 1'b1, 64, 16, "R3");
        window(15, 1'b0, 1'b1, 32768, 2, "R3");
        // R4: codes 1 and 2 behave as 8 and 9.
        window(1, 1'b1, 1'b0, 512, 4, "R4");
        window(2, 1'b1, 1'b1, 512, 2, "R4");
        // R6 / R7: each enable alone.
        window(5, 1'b1, 1'b0, 256, 16, "R6");
        window(5, 1'b0, 1'b1, 256, 16, "R7");
        // R8: no ticks, nothing happens and the count holds.
        for (int i = 0; i < 200; i++) step(1'b0, 3, 1'b1, 1'b1, "R8");
        // R5: rate change lands on next multiple of new period.
        for (int i = 0; i < 37; i++) step(1'b1, 4, 1'b1, 1'b0, "R5");
        for (int i = 0; i < 300; i++) step(1'b1, 7, 1'b1, 1'b0, "R5");

        // Random mix: codes, enables, sparse ticks and rate changes.
        for (int blk = 0; blk < 200; blk++) begin
            int code = int'($urandom_range(0, 9));
            bit pe = 1'($urandom_range(0, 1));
            bit se = 1'($urandom_range(0, 1));
            int len = int'($urandom_range(20, 200));
            for (int i = 0; i < len; i++)
                step(($urandom_range(0, 7) != 0), code, pe, se,
                     (code == 0) ? "R2" : "R5");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule